// File: doc/BRIEF.md
# Fault Injection Countdown Timer

This block schedules one injected fault for one error record. Software writes a countdown value through a small register port and sets an enable bit together with a mask of error types it may inject. When the unit is armed, the stored value is copied into a hidden counter. Software cannot read that counter. While the unit stays enabled, the counter moves down by one on each cycle in which the `tick` strobe is high. When it reaches zero, the block raises a one-cycle injection pulse. The pulse carries one of the enabled error types, given as a one-hot vector.

The `tick` strobe is a separate input, so the countdown rate does not depend on the register clock. The unit is armed in one of two ways: the countdown register is written while the enable bit is already set, or the enable bit is written from 0 to 1. Either event loads the counter. Each load produces at most one pulse, and the counter then idles at zero until the next load.

Top module: `finj_countdown`

## Requirements
- R1: After a synchronous reset, the countdown register, the control register and the hidden counter all read or behave as zero, and no pulse is issued.
- R2: The countdown register is 64 bits wide and sits at byte offset 0x810 + 64*REC_INDEX. A read returns the low 32 bits as last written. Bits [63:32] read as zero, and values written to them are discarded.
- R3: Writing the countdown register while the enable bit is 1 reloads the hidden counter with the written value and restarts the count from that value.
- R4: Writing the control register so that the enable bit goes from 0 to 1 loads the hidden counter with the stored countdown value.
- R5: A load of value N>0, followed by ticks while enabled, gives exactly one pulse. The pulse appears in the cycle after the edge that samples the N-th tick. Cycles without a tick do not count.
- R6: While the enable bit is 0, ticks never decrement the counter and no pulse is issued.
- R7: Each load gives at most one pulse. Afterwards the counter stays at zero and further ticks issue nothing.
- R8: When the mask has several bits set, the pulse carries a one-hot `inj_type` that marks the lowest-numbered set bit. Outside a pulse, `inj_type` is zero.
- R9: Loading the value zero issues no pulse.
- R10: With an all-zero mask, the counter still runs down, but no pulse is issued.
- R11: The control register sits at byte offset 0x808 + 64*REC_INDEX. Its bits [NUM_ERR-1:0] hold the error mask and bit 31 holds the enable. All other bits read as zero.
- R12: A read request is answered one clock later with `rsp_valid` high. Writes to any other address change nothing, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the record group |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 64 | Read data |
| tick | input | 1 | Single-cycle decrement strobe |
| inj_valid | output | 1 | One-cycle injection pulse |
| inj_type | output | NUM_ERR | One-hot selected error type, zero when idle |

## Verification
A register write takes effect at the clock edge that samples it, so a load and the first decrement can never share an edge. The bench therefore drives `tick` low during every write cycle. Read data is checked at the falling edge one cycle after the request. The pulse is registered, so it is checked at the falling edge right after the rising edge that samples the N-th tick. The bench counts the ticks it has applied and compares `inj_valid` and `inj_type` against that count on every cycle of each countdown window, not only at the expected pulse.

// File: rtl/finj_pkg.sv
package finj_pkg;
    localparam int CDN_BASE   = 'h810;
    localparam int CTL_BASE   = 'h808;
    localparam int REC_STRIDE = 64;
    localparam int EN_BIT     = 31;
    localparam int REG_W      = 64;
endpackage

// File: rtl/finj_pick.sv
module finj_pick #(
    parameter int NUM_ERR = 8
) (
    input  logic [NUM_ERR-1:0] mask,
    output logic [NUM_ERR-1:0] onehot,
    output logic               any
);
    logic [NUM_ERR:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_chain
        assign below[i+1] = below[i] | mask[i];
        assign onehot[i]  = mask[i] & ~below[i];
    end
    assign any = below[NUM_ERR];
endmodule

// File: rtl/finj_counter.sv
module finj_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic             tick,
    output logic             hit_zero,
    output logic             cnt_zero
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        hit_zero = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (en && tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            hit_zero = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_zero = (st_q.cnt == '0);

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && en && tick && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !(en && tick)) |=> $stable(st_q.cnt));
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_zero) |=> cnt_zero);
endmodule

// File: rtl/finj_regs.sv
module finj_regs
    import finj_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REC_INDEX = 0,
    parameter int NUM_ERR   = 8,
    parameter int CNT_W     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [REG_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_rdata,
    output logic               en,
    output logic [NUM_ERR-1:0] mask,
    output logic               load,
    output logic [CNT_W-1:0]   load_val
);
    localparam logic [ADDR_W-1:0] CDN_ADDR = ADDR_W'(CDN_BASE + REC_STRIDE * REC_INDEX);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CTL_BASE + REC_STRIDE * REC_INDEX);

    typedef struct packed {
        logic [CNT_W-1:0]   cdn;
        logic               en;
        logic [NUM_ERR-1:0] mask;
        logic               rsp_valid;
        logic [REG_W-1:0]   rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic hit_cdn, hit_ctl;
    logic unused_wbits;

    assign unused_wbits = ^req_wdata[REG_W-1:CNT_W];

    always_comb begin
        st_d           = st_q;
        hit_cdn        = req_valid && (req_addr == CDN_ADDR);
        hit_ctl        = req_valid && (req_addr == CTL_ADDR);
        load           = 1'b0;
        load_val       = st_q.cdn;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rdata     = '0;
        if (req_write) begin
            if (hit_cdn) begin
                st_d.cdn = req_wdata[CNT_W-1:0];
                load_val = req_wdata[CNT_W-1:0];
                load     = st_q.en;
            end
            if (hit_ctl) begin
                st_d.en   = req_wdata[EN_BIT];
                st_d.mask = req_wdata[NUM_ERR-1:0];
                load      = req_wdata[EN_BIT] && !st_q.en;
            end
        end else begin
            if (hit_cdn) st_d.rdata[CNT_W-1:0] = st_q.cdn;
            if (hit_ctl) begin
                st_d.rdata[EN_BIT]      = st_q.en;
                st_d.rdata[NUM_ERR-1:0] = st_q.mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rdata;
    assign en        = st_q.en;
    assign mask      = st_q.mask;

    p_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_rdata[REG_W-1:CNT_W] == '0);
    p_rsp_timing_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    p_load_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> en);
endmodule

// File: rtl/finj_countdown.sv
module finj_countdown
    import finj_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REC_INDEX = 0,
    parameter int NUM_ERR   = 8,
    parameter int CNT_W     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [63:0]        rsp_rdata,
    input  logic               tick,
    output logic               inj_valid,
    output logic [NUM_ERR-1:0] inj_type
);
    typedef struct packed {
        logic               valid;
        logic [NUM_ERR-1:0] kind;
    } inj_state_t;

    inj_state_t st_d, st_q;
    logic               en, load, hit_zero, cnt_zero, mask_any;
    logic [NUM_ERR-1:0] mask, pick;
    logic [CNT_W-1:0]   load_val;

    finj_regs #(.ADDR_W(ADDR_W), .REC_INDEX(REC_INDEX), .NUM_ERR(NUM_ERR), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .en(en), .mask(mask), .load(load), .load_val(load_val)
    );

    finj_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .en(en),
        .tick(tick), .hit_zero(hit_zero), .cnt_zero(cnt_zero)
    );

    finj_pick #(.NUM_ERR(NUM_ERR)) u_pick (
        .mask(mask), .onehot(pick), .any(mask_any)
    );

    always_comb begin
        st_d.valid = hit_zero && mask_any;
        st_d.kind  = (hit_zero && mask_any) ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign inj_valid = st_q.valid;
    assign inj_type  = st_q.kind;

    p_pulse_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        inj_valid |-> cnt_zero);
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        inj_valid |=> !inj_valid);
    p_type_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        inj_valid |-> $countones(inj_type) == 1);
    p_type_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !inj_valid |-> inj_type == '0);
    p_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        inj_valid |-> $past(en));
endmodule

// File: tb/finj_countdown_test.sv
module finj_countdown_test;
    localparam int ADDR_W = 16;
    localparam int NE     = 8;
    localparam int IDX    = 2;
    localparam logic [15:0] A_CDN = 16'h810 + 16'(64 * IDX);
    localparam logic [15:0] A_CTL = 16'h808 + 16'(64 * IDX);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, tick = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, inj_valid;
    logic [63:0] rsp_rdata;
    logic [NE-1:0] inj_type;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    finj_countdown #(.ADDR_W(ADDR_W), .REC_INDEX(IDX), .NUM_ERR(NE), .CNT_W(32)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .tick(tick), .inj_valid(inj_valid), .inj_type(inj_type)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; tick = 0;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        req_valid = 1; req_write = 0; req_addr = a; tick = 0;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R12 rsp_valid", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
    endtask

    function automatic logic [63:0] ctl(input bit e, input logic [NE-1:0] m);
        return {32'h0, e, 23'h0, m};
    endfunction

    // Ticks every per-th cycle; pulse expected right after the n-th sampled tick.
    task automatic run(input int n, input int per, input bit fire, input logic [NE-1:0] m,
                       input int cycles, input string req);
        int ticks = 0;
        logic [NE-1:0] low;
        low = m & (~m + NE'(1));
        for (int c = 0; c < cycles; c++) begin
            bit t, ev;
            t = ((c % per) == per - 1);
            tick = t;
            @(negedge clk);
            if (t) ticks++;
            ev = fire && t && (ticks == n);
            chk(inj_valid == ev, req, 64'(inj_valid), 64'(ev));
            chk(inj_type == (ev ? low : '0), "R8 type", 64'(inj_type), 64'(ev ? low : '0));
        end
        tick = 0;
    endtask

    task automatic arm(input int n, input logic [NE-1:0] m);
        wr(A_CTL, ctl(0, m));
        wr(A_CDN, 64'(n));
        wr(A_CTL, ctl(1, m));
    endtask

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(inj_valid == 0, "R1 pulse", 64'(inj_valid), 0);
        rd(A_CDN, d); chk(d == 0, "R1 cdn", d, 0);
        rd(A_CTL, d); chk(d == 0, "R1 ctl", d, 0);
        // R2 / R11 register layout
        wr(A_CDN, 64'hDEAD_BEEF_1234_5678);
        rd(A_CDN, d); chk(d == 64'h1234_5678, "R2 readback", d, 64'h1234_5678);
        wr(A_CTL, 64'hFFFF_FFFF_7FFF_FF5A);
        rd(A_CTL, d); chk(d == 64'h5A, "R11 ctl", d, 64'h5A);
        // R12 foreign addresses
        wr(16'h810, 64'h77); wr(16'h808, 64'h8000_00FF); wr(A_CDN + 16'd8, 64'h99);
        rd(A_CDN, d); chk(d == 64'h1234_5678, "R12 cdn kept", d, 64'h1234_5678);
        rd(A_CTL, d); chk(d == 64'h5A, "R12 ctl kept", d, 64'h5A);
        rd(16'h810, d); chk(d == 0, "R12 foreign read", d, 0);
        // R1 with the unit disabled, nothing fires on ticks
        run(0, 1, 0, 8'h0, 10, "R1 idle");
        // R5 / R9 sweep of counts and tick spacings
        for (int p = 1; p <= 3; p++)
            for (int n = 0; n <= 12; n++) begin
                arm(n, 8'h24);
                run(n, p, n > 0, 8'h24, n * p + 6, n == 0 ? "R9 zero load" : "R5 countdown");
            end
        // R4 enable edge loads the stored value; R11 enable bit reads back
        arm(5, 8'h01);
        rd(A_CTL, d); chk(d == 64'h8000_0001, "R11 enable bit", d, 64'h8000_0001);
        run(5, 2, 1, 8'h01, 16, "R4 arm");
        // R7 no second pulse after reaching zero
        run(0, 1, 0, 8'h01, 30, "R7 no refire");
        // R8 exhaustive mask sweep, R10 for mask zero
        for (int m = 0; m < 256; m++) begin
            arm(2, NE'(m));
            run(2, 1, m != 0, NE'(m), 5, m == 0 ? "R10 empty mask" : "R8 mask");
        end
        // R3 rewrite while enabled restarts the count
        arm(10, 8'h80);
        run(0, 1, 0, 8'h80, 4, "R3 before rewrite");
        wr(A_CDN, 64'd3);
        run(3, 1, 1, 8'h80, 8, "R3 reload");
        // R6 disabled unit ignores ticks
        arm(4, 8'h10);
        run(0, 1, 0, 8'h10, 2, "R6 partial");
        wr(A_CTL, ctl(0, 8'h10));
        run(0, 1, 0, 8'h10, 20, "R6 disabled");
        // R2 write with enable 0 stores but does not load
        wr(A_CDN, 64'd2);
        run(0, 1, 0, 8'h10, 6, "R2 no load when off");
        wr(A_CTL, ctl(1, 8'h10));
        run(2, 1, 1, 8'h10, 6, "R4 rearm");
        // R1 reset clears registers mid-count
        arm(6, 8'h02);
        rst = 1; @(negedge clk); rst = 0;
        run(0, 1, 0, 8'h02, 10, "R1 reset clears");
        rd(A_CDN, d); chk(d == 0, "R1 cdn after reset", d, 0);
        finish_run();
    end
endmodule